// File: doc/BRIEF.md
# Timer DMA Burst Register Redirector

This block lets a single timer event start a burst of DMA transfers. Each transfer goes to one fixed burst data address. The block sends every access at that address on to one of a bank of real timer registers. The first target is a programmable base offset. Each later transfer of the burst moves to the next register. A DMA controller that always points at the same address can therefore reprogram several timer registers, or read several of them in a row, from one event and without software.

A small register port carries two locations. The burst configuration register holds a 5-bit base offset and a 5-bit length. The burst data port is the redirected window. Offset 0 is the first control register, offset 1 the second, offset 2 the slave-mode control register, and later offsets follow in address order. The request line rises on the event. It drops for one cycle after each accepted data-port access and rises again until the last transfer has been served. The whole register bank is exposed as a flat output for the counter and compare logic to use.

Top module: `tim_dma_burst`

## Requirements
- R1: `bus_sel_i`=0 selects the configuration register and `bus_sel_i`=1 selects the burst data port. In the configuration register the base offset is bits [4:0] and the length is bits [12:8]. A read returns both fields with all other bits zero, and the reset value is zero.
- R2: An `event_i` pulse while no burst is running makes `dma_req_o` high on the next cycle, with the transfer index at 0.
- R3: Transfer n of a burst, counting from 0, accesses register index base+n. A burst holds length+1 transfers, so a length of 0 means one transfer.
- R4: After each accepted data-port access that is not the last of the burst, `dma_req_o` is low for exactly one cycle and then high again.
- R5: After the last transfer `dma_req_o` stays low and the index returns to 0, so a data-port access while idle reaches register `base`.
- R6: An `event_i` pulse during a running burst is ignored. The burst continues with its current index and ends after its original count.
- R7: When base+n is at or past `NUM_REGS`, a write is dropped and a read returns zero. The transfer still counts toward the end of the burst.
- R8: A write to the configuration register aborts a running burst. On the next cycle `dma_req_o` is low and the index is 0.
- R9: A data-port read returns the addressed register. Register k appears on `regs_o[k*DW +: DW]`, and all registers reset to zero.
- R10: `bus_ack_o` follows `bus_valid_i` in the same cycle, read data is valid in that same cycle, and a write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 1 | Timer event that starts a burst |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_sel_i | input | 1 | 0 = configuration register, 1 = burst data port |
| bus_wdata_i | input | DW | Write data |
| bus_ack_o | output | 1 | Access acknowledge |
| bus_rdata_o | output | DW | Read data |
| dma_req_o | output | 1 | DMA request line |
| regs_o | output | NUM_REGS*DW | Flattened target register bank |

## Verification
The bench builds the block with `NUM_REGS`=6 and `DW`=16. With only six registers, bases 0 to 7 combined with lengths 0 to 3 cover three kinds of burst: bursts fully in range, bursts that run off the end of the bank, and bursts that start already out of range. Every one of them runs as a write burst and then as a read burst against an arithmetic model. Directed runs cover a second event during a burst and an abort by a configuration write. A final run uses the largest field values (base 31, length 31), which drives the widened target sum to its maximum of 62.

// File: rtl/tdbr_pkg.sv
package tdbr_pkg;
  localparam int unsigned FIELD_W = 5;
  localparam int unsigned TGT_W   = FIELD_W + 1;
  localparam int unsigned BASE_LSB = 0;
  localparam int unsigned LEN_LSB  = 8;
  localparam int unsigned CFG_MIN_DW = LEN_LSB + FIELD_W;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [FIELD_W-1:0] len;
    logic [FIELD_W-1:0] base;
  } burst_cfg_t;
endpackage

// File: rtl/dbr_cfg_reg.sv
module dbr_cfg_reg
  import tdbr_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output burst_cfg_t    cfg_o,
  output logic [DW-1:0] rdata_o
);
  burst_cfg_t cfg_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      cfg_q.base <= wdata_i[BASE_LSB +: FIELD_W];
      cfg_q.len  <= wdata_i[LEN_LSB +: FIELD_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[BASE_LSB +: FIELD_W] = cfg_q.base;
    rdata_o[LEN_LSB +: FIELD_W]  = cfg_q.len;
  end

  assign cfg_o = cfg_q;

  initial begin
    if (DW < CFG_MIN_DW) $error("DW too narrow for burst configuration fields");
  end

  // R1
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cfg_o.base == $past(wdata_i[BASE_LSB +: FIELD_W])) &&
             (cfg_o.len  == $past(wdata_i[LEN_LSB +: FIELD_W])));
endmodule

// File: rtl/dbr_seq.sv
module dbr_seq
  import tdbr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               event_i,
  input  logic               acc_i,
  input  logic               abort_i,
  input  burst_cfg_t         cfg_i,
  output logic               req_o,
  output logic [FIELD_W-1:0] idx_o
);
  seq_state_e         state_q;
  logic [FIELD_W-1:0] idx_q;
  logic               last;

  assign last = (idx_q == cfg_i.len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else if (abort_i) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (event_i) begin
            state_q <= SEQ_REQ;
            idx_q   <= '0;
          end
        end
        SEQ_REQ, SEQ_GAP: begin
          if (acc_i) begin
            if (last) begin
              state_q <= SEQ_IDLE;
              idx_q   <= '0;
            end else begin
              state_q <= SEQ_GAP;
              idx_q   <= idx_q + 1'b1;
            end
          end else if (state_q == SEQ_GAP) begin
            state_q <= SEQ_REQ;
          end
        end
        default: begin
          state_q <= SEQ_IDLE;
          idx_q   <= '0;
        end
      endcase
    end
  end

  assign req_o = (state_q == SEQ_REQ);
  assign idx_o = idx_q;

  // R2
  start_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && event_i && !abort_i) |=> (req_o && idx_o == '0));
  // R3
  idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SEQ_IDLE && !abort_i) |-> (idx_q <= cfg_i.len));
  // R4
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SEQ_IDLE && acc_i && !abort_i && !last) |=>
      (!req_o && idx_q == $past(idx_q) + 1'b1));
  // R5
  last_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SEQ_IDLE && acc_i && !abort_i && last) |=>
      (state_q == SEQ_IDLE && idx_q == '0 && !req_o));
  // R6
  ignore_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SEQ_IDLE && event_i && !acc_i && !abort_i) |=>
      ($stable(idx_q) && state_q != SEQ_IDLE));
  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == SEQ_IDLE && idx_q == '0 && !req_o));
endmodule

// File: rtl/dbr_regfile.sv
module dbr_regfile
  import tdbr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 20,
  parameter int unsigned DW       = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [TGT_W-1:0]       tgt_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic in_range;

  assign in_range = (32'(tgt_i) < NUM_REGS);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (we_i && tgt_i == TGT_W'(k))  q <= wdata_i;
    end
    assign regs_o[k*DW +: DW] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < int'(NUM_REGS); k++) begin
      if (tgt_i == TGT_W'(k)) rdata_o = regs_o[k*DW +: DW];
    end
  end

  initial begin
    if (NUM_REGS > 63) $error("NUM_REGS beyond reachable target range");
  end

  // R7
  oob_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !in_range) |=> $stable(regs_o));
  // R7
  oob_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |-> (rdata_o == '0));
endmodule

// File: rtl/tim_dma_burst.sv
module tim_dma_burst
  import tdbr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 20,
  parameter int unsigned DW       = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   event_i,
  input  logic                   bus_valid_i,
  input  logic                   bus_write_i,
  input  logic                   bus_sel_i,
  input  logic [DW-1:0]          bus_wdata_i,
  output logic                   bus_ack_o,
  output logic [DW-1:0]          bus_rdata_o,
  output logic                   dma_req_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  burst_cfg_t         cfg;
  logic [DW-1:0]      cfg_rdata;
  logic [DW-1:0]      rf_rdata;
  logic [FIELD_W-1:0] idx;
  logic [TGT_W-1:0]   tgt;
  logic               cfg_wr;
  logic               data_acc;

  assign cfg_wr   = bus_valid_i && bus_write_i && !bus_sel_i;
  assign data_acc = bus_valid_i && bus_sel_i;
  assign tgt      = {1'b0, cfg.base} + {1'b0, idx};

  dbr_cfg_reg #(.DW(DW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr),
    .wdata_i (bus_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata)
  );

  dbr_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (event_i),
    .acc_i   (data_acc),
    .abort_i (cfg_wr),
    .cfg_i   (cfg),
    .req_o   (dma_req_o),
    .idx_o   (idx)
  );

  dbr_regfile #(.NUM_REGS(NUM_REGS), .DW(DW)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (data_acc && bus_write_i),
    .tgt_i   (tgt),
    .wdata_i (bus_wdata_i),
    .rdata_o (rf_rdata),
    .regs_o  (regs_o)
  );

  assign bus_ack_o   = bus_valid_i;
  assign bus_rdata_o = bus_sel_i ? rf_rdata : cfg_rdata;

  // R9
  redirect_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && bus_write_i && 32'(tgt) < NUM_REGS) |=>
      (bus_sel_i || !bus_valid_i || bus_write_i ||
       regs_o[$past(tgt)*DW +: DW] == $past(bus_wdata_i)));
endmodule

// File: tb/tim_dma_burst_test.sv
`timescale 1ns/1ps
module tim_dma_burst_test;
  localparam int NR = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev = 1'b0;
  logic valid = 1'b0, wr = 1'b0, sel = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic ack, req;
  logic [DW-1:0] rdata;
  logic [NR*DW-1:0] regs;

  int vecs = 0;
  int errs = 0;
  logic [DW-1:0] model [NR];

  always #2.5 clk = ~clk;

  tim_dma_burst #(.NUM_REGS(NR), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev),
    .bus_valid_i(valid), .bus_write_i(wr), .bus_sel_i(sel),
    .bus_wdata_i(wdata), .bus_ack_o(ack), .bus_rdata_o(rdata),
    .dma_req_o(req), .regs_o(regs)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic s, input logic [DW-1:0] d,
                     output logic [DW-1:0] rd);
    @(negedge clk);
    valid = 1'b1; wr = w; sel = s; wdata = d;
    #1;
    rd = rdata;
    chk("R10 ack", 32'(ack), 32'd1);
    @(negedge clk);
    valid = 1'b0; wr = 1'b0;
  endtask

  task automatic set_cfg(input int b, input int l);
    logic [DW-1:0] rd;
    logic [DW-1:0] v;
    v = '0;
    v[4:0] = 5'(b);
    v[12:8] = 5'(l);
    acc(1'b1, 1'b0, v | 16'he0e0, rd);
    acc(1'b0, 1'b0, '0, rd);
    chk("R1 cfg readback", 32'(rd), 32'(v));
  endtask

  task automatic fire();
    @(negedge clk); ev = 1'b1;
    @(negedge clk); ev = 1'b0;
    chk("R2 req after event", 32'(req), 32'd1);
  endtask

  function automatic logic [DW-1:0] exp_reg(input int t);
    return (t < NR) ? model[t] : '0;
  endfunction

  task automatic check_regs(input string r);
    for (int k = 0; k < NR; k++) chk(r, 32'(regs[k*DW +: DW]), 32'(model[k]));
  endtask

  // transfer n of a burst; checks request behaviour around it
  task automatic xfer(input int n, input int len, input logic w, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd);
    if (n > 0) begin
      @(negedge clk);
      chk("R4 req back high", 32'(req), 32'd1);
    end
    acc(w, 1'b1, d, rd);
    if (n < len) chk("R4 req gap", 32'(req), 32'd0);
    else         chk("R5 req low at end", 32'(req), 32'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog R2 act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    logic [DW-1:0] d;
    for (int k = 0; k < NR; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 req at reset", 32'(req), 32'd0);
    check_regs("R9 reset regs");
    acc(1'b0, 1'b0, '0, rd);
    chk("R1 cfg reset", 32'(rd), 32'd0);

    // sweep base x length, write burst then read burst
    for (int b = 0; b < 8; b++) begin
      for (int l = 0; l < 4; l++) begin
        set_cfg(b, l);
        fire();
        for (int n = 0; n <= l; n++) begin
          d = DW'(b * 256 + l * 16 + n + 1);
          xfer(n, l, 1'b1, d, rd);
          if (b + n < NR) model[b + n] = d;
        end
        check_regs((b + l >= NR) ? "R7 regs after write burst" : "R3 regs after write burst");
        fire();
        for (int n = 0; n <= l; n++) begin
          xfer(n, l, 1'b0, '0, rd);
          chk((b + n >= NR) ? "R7 read out of range" : "R9 read burst",
              32'(rd), 32'(exp_reg(b + n)));
        end
        @(negedge clk);
        chk("R5 idle after burst", 32'(req), 32'd0);
        acc(1'b0, 1'b1, '0, rd);
        chk("R5 idle read hits base", 32'(rd), 32'(exp_reg(b)));
        chk("R5 idle access no req", 32'(req), 32'd0);
      end
    end

    // R6: events during a running burst
    set_cfg(1, 3);
    fire();
    fire();
    for (int n = 0; n <= 3; n++) begin
      d = DW'(16'ha000 + n);
      if (n == 1) begin
        @(negedge clk); ev = 1'b1;
        @(negedge clk); ev = 1'b0;
        chk("R6 burst continues", 32'(req), 32'd1);
        acc(1'b1, 1'b1, d, rd);
        chk("R6 req gap", 32'(req), 32'd0);
      end else begin
        xfer(n, 3, 1'b1, d, rd);
      end
      model[1 + n] = d;
    end
    @(negedge clk);
    chk("R6 burst ends after original count", 32'(req), 32'd0);
    check_regs("R6 regs");

    // R8: abort by configuration write
    set_cfg(2, 3);
    fire();
    xfer(0, 3, 1'b1, 16'hbeef, rd);
    model[2] = 16'hbeef;
    set_cfg(2, 3);
    chk("R8 req low after abort", 32'(req), 32'd0);
    @(negedge clk);
    chk("R8 stays idle", 32'(req), 32'd0);
    acc(1'b1, 1'b1, 16'h1234, rd);
    model[2] = 16'h1234;
    check_regs("R8 index reset to base");

    // R7: largest fields, everything out of range
    set_cfg(31, 31);
    fire();
    for (int n = 0; n <= 31; n++) xfer(n, 31, 1'b1, DW'(16'hc000 + n), rd);
    @(negedge clk);
    chk("R7 long burst completes", 32'(req), 32'd0);
    check_regs("R7 long burst dropped");

    finish_run();
  end
endmodule